// File: doc/BRIEF.md
# Class-Latency Issue Interlock

This block sits beside the decode stage of an in-order, single-issue pipeline and decides in every cycle whether the instruction now in decode may leave for execute. Each pairing of a producing instruction class with a consuming instruction class needs a minimum number of empty cycles between the two. That number comes from a small producer-by-consumer latency function, not from one fixed load-use rule. The block keeps a short shift history of recent issue slots. Each slot records the destination register, which register file it belongs to, and the producer class. The slot's position in the history gives its age in cycles.

All hazard checks take place before issue. An instruction leaves decode only when none of its source operands is waiting on a producer that is still too young, and only when its own write cannot land before the write of an older in-flight instruction to the same register. Once issued, an instruction is never recalled. While the block stalls, the decode stage and everything behind it hold still and execute receives an empty slot. That empty slot enters the history as an invalid entry, and every entry ages by one each cycle whether or not anything issued.

Top module: `iil_interlock`

## Requirements
- R1: A synchronous reset empties the history. In the first cycle after reset, with no instruction presented, issue and stall are low and bubble is high, and any presented instruction issues at once.
- R2: The class field uses these codes: 0 none, 1 integer ALU, 2 integer load, 3 integer store, 4 FP ALU, 5 FP load, 6 FP store, 7 none. Operand A is read by codes 1 to 6, and it is an FP register only for code 4. Operand B is read by codes 1, 3, 4 and 6, and it is an FP register for codes 4 and 6. Codes 1 and 2 write an integer destination and codes 4 and 5 write an FP destination. Issue is high when valid is high and no hazard exists. Stall is high only when valid is high and a hazard exists. Bubble is high whenever issue is low.
- R3: An FP ALU consumer of an FP ALU result stalls until three cycles have passed after the producer issued. It issues in the fourth cycle.
- R4: The FP store data operand, when fed by an FP ALU result, needs two empty cycles before it may issue.
- R5: An FP ALU consumer of an FP load result needs one empty cycle.
- R6: The FP store data operand, when fed by an FP load, issues in the very next cycle.
- R7: An integer consumer of an integer load result needs one empty cycle. An integer ALU result may be consumed in the next cycle.
- R8: A register number match counts only when both sides are in the same register file.
- R9: Integer register 0 never causes a hazard, as a source or as a destination.
- R10: A writer stalls while the sum of the age of an older in-flight writer of the same register and the writer's own result delay is at most the older writer's result delay. Result delays are 3 for FP ALU, 1 for both loads and 0 for integer ALU.
- R11: Stalled and idle cycles count toward a producer's age, so the waiting consumer issues in exactly the cycle the latency allows.
- R12: Writing a register that an older instruction read causes no stall, and stores leave no entry in the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| id_valid_i | input | 1 | An instruction is present in decode |
| id_cls_i | input | 3 | Class code of the decode instruction |
| src_a_i | input | REG_W | Operand A register number |
| src_b_i | input | REG_W | Operand B register number |
| dst_i | input | REG_W | Destination register number |
| issue_o | output | 1 | Decode instruction moves to execute this cycle |
| stall_o | output | 1 | Hold decode and all younger stages |
| bubble_o | output | 1 | Execute receives an empty slot |

## Verification
A history slot that is lost, shifted twice or left uncleared shows up at the ports within the next three cycles. It appears as a stall that ends one cycle early or late, or as a stall with no producer behind it. A wrong file flag or class in a slot shows up as a missing or spurious stall on the first dependent instruction. For that reason the vectors place each consumer at every age around its latency limit, check the cycle when the stall ends, and cross register files with the same register numbers.

// File: rtl/iil_pkg.sv
package iil_pkg;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_IALU   = 3'd1,
        CLS_ILOAD  = 3'd2,
        CLS_ISTORE = 3'd3,
        CLS_FALU   = 3'd4,
        CLS_FLOAD  = 3'd5,
        CLS_FSTORE = 3'd6,
        CLS_RSVD   = 3'd7
    } icls_e;

    localparam int CLS_W = 3;

    // empty cycles needed between producer issue and consumer issue
    function automatic int gap_cycles(icls_e prod, icls_e cons);
        case (prod)
            CLS_ILOAD: return 1;
            CLS_FALU:  return (cons == CLS_FSTORE) ? 2 : 3;
            CLS_FLOAD: return (cons == CLS_FSTORE) ? 0 : 1;
            default:   return 0;
        endcase
    endfunction

    // cycles from issue until the result is written back
    function automatic int result_lag(icls_e c);
        case (c)
            CLS_FALU:  return 3;
            CLS_ILOAD: return 1;
            CLS_FLOAD: return 1;
            default:   return 0;
        endcase
    endfunction

    function automatic logic has_dst(icls_e c);
        return (c == CLS_IALU) || (c == CLS_ILOAD) || (c == CLS_FALU) || (c == CLS_FLOAD);
    endfunction

    function automatic logic dst_fp(icls_e c);
        return (c == CLS_FALU) || (c == CLS_FLOAD);
    endfunction

    function automatic logic use_a(icls_e c);
        return (c != CLS_NONE) && (c != CLS_RSVD);
    endfunction

    function automatic logic a_fp(icls_e c);
        return c == CLS_FALU;
    endfunction

    function automatic logic use_b(icls_e c);
        return (c == CLS_IALU) || (c == CLS_ISTORE) || (c == CLS_FALU) || (c == CLS_FSTORE);
    endfunction

    function automatic logic b_fp(icls_e c);
        return (c == CLS_FALU) || (c == CLS_FSTORE);
    endfunction

endpackage

// File: rtl/iil_history.sv
module iil_history
    import iil_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = 3,
    localparam int ENT_W = 2 + CLS_W + REG_W
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        push_vld_i,
    input  logic                        push_fp_i,
    input  logic [CLS_W-1:0]            push_cls_i,
    input  logic [REG_W-1:0]            push_dst_i,
    output logic [DEPTH-1:0][ENT_W-1:0] hist_o
);

    typedef struct packed {
        logic             vld;
        logic             fp;
        logic [CLS_W-1:0] cls;
        logic [REG_W-1:0] dst;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] slot;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        // slot 0 receives this cycle's issue slot (age 1 next cycle)
        hist_d.slot[0].vld = push_vld_i;
        hist_d.slot[0].fp  = push_fp_i;
        hist_d.slot[0].cls = push_cls_i;
        hist_d.slot[0].dst = push_dst_i;
        for (int i = 1; i < DEPTH; i++) begin
            hist_d.slot[i] = hist_q.slot[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= hist_d;
    end

    assign hist_o = hist_q.slot;

endmodule

// File: rtl/iil_match.sv
module iil_match
    import iil_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int AGE   = 1,
    localparam int ENT_W = 2 + CLS_W + REG_W
) (
    input  logic [ENT_W-1:0] ent_i,
    input  logic [CLS_W-1:0] cls_i,
    input  logic [REG_W-1:0] src_a_i,
    input  logic [REG_W-1:0] src_b_i,
    input  logic [REG_W-1:0] dst_i,
    output logic             raw_o,
    output logic             waw_o
);

    typedef struct packed {
        logic             vld;
        logic             fp;
        logic [CLS_W-1:0] cls;
        logic [REG_W-1:0] dst;
    } ent_t;

    ent_t  ent;
    icls_e cons, prod;
    logic  ent_live, hit_a, hit_b, hit_d, young_raw, young_waw;

    assign ent  = ent_t'(ent_i);
    assign cons = icls_e'(cls_i);
    assign prod = icls_e'(ent.cls);

    // integer r0 is a constant sink: an entry for it is never live
    assign ent_live = ent.vld && (ent.fp || (ent.dst != '0));

    assign hit_a = use_a(cons) && (a_fp(cons) == ent.fp) && (src_a_i == ent.dst);
    assign hit_b = use_b(cons) && (b_fp(cons) == ent.fp) && (src_b_i == ent.dst);
    assign hit_d = has_dst(cons) && (dst_fp(cons) == ent.fp) && (dst_i == ent.dst);

    assign young_raw = AGE <= gap_cycles(prod, cons);
    assign young_waw = (AGE + result_lag(cons)) <= result_lag(prod);

    assign raw_o = ent_live && young_raw && (hit_a || hit_b);
    assign waw_o = ent_live && young_waw && hit_d;

endmodule

// File: rtl/iil_hazard.sv
module iil_hazard
    import iil_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = 3,
    localparam int ENT_W = 2 + CLS_W + REG_W
) (
    input  logic [DEPTH-1:0][ENT_W-1:0] hist_i,
    input  logic [CLS_W-1:0]            cls_i,
    input  logic [REG_W-1:0]            src_a_i,
    input  logic [REG_W-1:0]            src_b_i,
    input  logic [REG_W-1:0]            dst_i,
    output logic                        hazard_o
);

    logic [DEPTH-1:0] raw_vec, waw_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        iil_match #(
            .REG_W (REG_W),
            .AGE   (g + 1)
        ) u_match (
            .ent_i   (hist_i[g]),
            .cls_i   (cls_i),
            .src_a_i (src_a_i),
            .src_b_i (src_b_i),
            .dst_i   (dst_i),
            .raw_o   (raw_vec[g]),
            .waw_o   (waw_vec[g])
        );
    end

    assign hazard_o = |{raw_vec, waw_vec};

endmodule

// File: rtl/iil_interlock.sv
module iil_interlock
    import iil_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             id_valid_i,
    input  logic [2:0]       id_cls_i,
    input  logic [REG_W-1:0] src_a_i,
    input  logic [REG_W-1:0] src_b_i,
    input  logic [REG_W-1:0] dst_i,
    output logic             issue_o,
    output logic             stall_o,
    output logic             bubble_o
);

    localparam int ENT_W = 2 + CLS_W + REG_W;

    icls_e                       cls;
    logic                        hazard, push_vld, push_fp;
    logic [DEPTH-1:0][ENT_W-1:0] hist;

    assign cls = icls_e'(id_cls_i);

    iil_hazard #(
        .REG_W (REG_W),
        .DEPTH (DEPTH)
    ) u_hazard (
        .hist_i   (hist),
        .cls_i    (id_cls_i),
        .src_a_i  (src_a_i),
        .src_b_i  (src_b_i),
        .dst_i    (dst_i),
        .hazard_o (hazard)
    );

    assign issue_o  = id_valid_i && !hazard;
    assign stall_o  = id_valid_i && hazard;
    assign bubble_o = !issue_o;

    // only real register writes become live history slots
    assign push_fp  = dst_fp(cls);
    assign push_vld = issue_o && has_dst(cls) && (push_fp || (dst_i != '0));

    iil_history #(
        .REG_W (REG_W),
        .DEPTH (DEPTH)
    ) u_hist (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .push_vld_i (push_vld),
        .push_fp_i  (push_fp),
        .push_cls_i (id_cls_i),
        .push_dst_i (dst_i),
        .hist_o     (hist)
    );

endmodule

// File: rtl/iil_interlock_chk.sv
module iil_interlock_chk #(
    parameter int REG_W = 5
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             id_valid_i,
    input logic [2:0]       id_cls_i,
    input logic [REG_W-1:0] src_a_i,
    input logic [REG_W-1:0] src_b_i,
    input logic [REG_W-1:0] dst_i,
    input logic             issue_o,
    input logic             stall_o,
    input logic             bubble_o
);

    AST_STALL_NEEDS_INSTR: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |-> (id_valid_i && bubble_o)); // R2

    AST_CLEAN_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !stall_o); // R1

    AST_FALU_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i && issue_o && id_cls_i == 3'd4) && id_valid_i &&
         id_cls_i == 3'd4 && src_a_i == $past(dst_i)) |-> stall_o); // R3

    AST_ZERO_REG_FREE: assert property (@(posedge clk_i) disable iff (rst_i)
        (id_valid_i && id_cls_i == 3'd1 && src_a_i == '0 && src_b_i == '0 && dst_i == '0)
        |-> issue_o); // R9

endmodule

bind iil_interlock iil_interlock_chk #(.REG_W(REG_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .id_valid_i (id_valid_i),
    .id_cls_i   (id_cls_i),
    .src_a_i    (src_a_i),
    .src_b_i    (src_b_i),
    .dst_i      (dst_i),
    .issue_o    (issue_o),
    .stall_o    (stall_o),
    .bubble_o   (bubble_o)
);

// File: tb/iil_interlock_bench.sv
module iil_interlock_bench;

    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             vld = 1'b0;
    logic [2:0]       cls = '0;
    logic [REG_W-1:0] sa  = '0;
    logic [REG_W-1:0] sb  = '0;
    logic [REG_W-1:0] dd  = '0;
    logic             issue, stall, bubble;
    int               n_run  = 0;
    int               n_fail = 0;
    logic             done = 1'b0;

    always #5 clk = ~clk;

    iil_interlock #(.REG_W(REG_W)) u_iil_interlock (
        .clk_i      (clk),
        .rst_i      (rst),
        .id_valid_i (vld),
        .id_cls_i   (cls),
        .src_a_i    (sa),
        .src_b_i    (sb),
        .dst_i      (dd),
        .issue_o    (issue),
        .stall_o    (stall),
        .bubble_o   (bubble)
    );

    typedef struct packed {
        logic       v;
        logic [2:0] c;
        logic [4:0] a;
        logic [4:0] b;
        logic [4:0] d;
        logic       iss;
        logic [3:0] req;
    } vec_t;

    // classes: 1 IALU 2 ILOAD 3 ISTORE 4 FALU 5 FLOAD 6 FSTORE
    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd4,  2,  3,  1, 1'b1, 4'd1 },  // R1 FALU f1
        '{1'b1, 3'd4,  1,  4,  5, 1'b0, 4'd3 },  // R3 age 1
        '{1'b1, 3'd4,  1,  4,  5, 1'b0, 4'd11},  // R11 age 2 during stall
        '{1'b1, 3'd4,  1,  4,  5, 1'b0, 4'd3 },  // R3 age 3
        '{1'b1, 3'd4,  1,  4,  5, 1'b1, 4'd3 },  // R3 issues 4th cycle
        '{1'b1, 3'd6,  2,  5,  0, 1'b0, 4'd4 },  // R4 age 1
        '{1'b1, 3'd6,  2,  5,  0, 1'b0, 4'd4 },  // R4 age 2
        '{1'b1, 3'd6,  2,  5,  0, 1'b1, 4'd4 },  // R4 age 3 issue
        '{1'b1, 3'd5,  2,  0,  6, 1'b1, 4'd5 },  // R5 FLOAD f6
        '{1'b1, 3'd4,  6,  0,  7, 1'b0, 4'd5 },  // R5 age 1 stall
        '{1'b1, 3'd4,  6,  0,  7, 1'b1, 4'd5 },  // R5 age 2 issue
        '{1'b1, 3'd5,  3,  0,  8, 1'b1, 4'd6 },  // R6 FLOAD f8
        '{1'b1, 3'd6,  3,  8,  0, 1'b1, 4'd6 },  // R6 store next cycle
        '{1'b1, 3'd2,  4,  0,  5, 1'b1, 4'd7 },  // R7 ILOAD r5
        '{1'b1, 3'd1,  5,  6,  7, 1'b0, 4'd7 },  // R7 load-use stall
        '{1'b1, 3'd1,  5,  6,  7, 1'b1, 4'd7 },  // R7 issue
        '{1'b1, 3'd1,  7,  7,  8, 1'b1, 4'd7 },  // R7 IALU forward
        '{1'b1, 3'd2,  0,  0,  9, 1'b1, 4'd9 },  // R9 base r0
        '{1'b1, 3'd4,  9,  9, 10, 1'b1, 4'd8 },  // R8 f9 vs r9
        '{1'b1, 3'd1, 10,  0, 11, 1'b1, 4'd8 },  // R8 r10 vs f10
        '{1'b1, 3'd2,  0,  0,  0, 1'b1, 4'd9 },  // R9 load into r0
        '{1'b1, 3'd1,  0,  0, 12, 1'b1, 4'd9 },  // R9 read r0
        '{1'b1, 3'd4,  1,  1, 12, 1'b1, 4'd10},  // R10 FALU f12
        '{1'b1, 3'd5,  1,  0, 12, 1'b0, 4'd10},  // R10 WAW age 1
        '{1'b1, 3'd5,  1,  0, 12, 1'b0, 4'd10},  // R10 WAW age 2
        '{1'b1, 3'd5,  1,  0, 12, 1'b1, 4'd10},  // R10 WAW age 3 issue
        '{1'b1, 3'd1, 13, 14, 15, 1'b1, 4'd12},  // R12 reads r13
        '{1'b1, 3'd1,  1,  1, 13, 1'b1, 4'd12},  // R12 WAR free
        '{1'b0, 3'd4, 12, 12,  1, 1'b0, 4'd2 },  // R2 no instruction
        '{1'b1, 3'd1, 13,  0, 14, 1'b1, 4'd2 },  // R2 after idle
        '{1'b1, 3'd3, 14, 14,  0, 1'b1, 4'd12}   // R12 store issues
    };

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // drive at negedge, sample just before the next rising edge
    task automatic step(input logic v, input logic [2:0] c, input logic [4:0] a,
                        input logic [4:0] b, input logic [4:0] d,
                        input logic exp_iss, input string tag);
        logic [2:0] got, exp;
        @(negedge clk);
        vld = v; cls = c; sa = a; sb = b; dd = d;
        #4;
        got = {issue, stall, bubble};
        exp = {exp_iss, v && !exp_iss, !exp_iss};   // R2
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: issue/stall/bubble actual=%b expected=%b", tag, got, exp);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 3'd0, 0, 0, 0, 1'b0, "R1 idle after reset");
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].v, VEC[i].c, VEC[i].a, VEC[i].b, VEC[i].d, VEC[i].iss,
                 $sformatf("R%0d vector %0d", VEC[i].req, i));
        end
        // reset clears an in-flight FP ALU producer
        step(1'b1, 3'd4, 21, 21, 20, 1'b1, "R1 producer");
        @(negedge clk);
        rst = 1'b1; vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #4;
        step(1'b1, 3'd4, 20, 21, 22, 1'b1, "R1 history cleared");
        // integer WAW: load then ALU to same register
        step(1'b1, 3'd2, 0, 0, 20, 1'b1, "R10 ILOAD r20");
        step(1'b1, 3'd1, 1, 1, 20, 1'b0, "R10 IALU WAW stall");
        step(1'b1, 3'd1, 1, 1, 20, 1'b1, "R10 IALU WAW issue");
        done = 1'b1;
        report();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            report();
        end
    end

endmodule